// File: doc/BRIEF.md
# Cut-Through Packet Switch Port

This block is a small crossbar for variable-length packets. Every packet begins with one header word, which carries the target output and the number of payload words that follow. An input port holds the header in its own register while a per-output arbiter decides whether the packet gets the output. Once an input owns an output, the packet goes out by one of two paths.

- **Bypass.** If the output buffer is empty and the downstream channel is ready when the grant is made, the words pass straight through to the output.
- **Buffer.** Otherwise the whole packet is written into that output's buffer, and it drains once the channel frees.

A mode input selects when a stored packet may start to drain. In whole-packet mode, draining waits until the last word of the packet is stored. In early-start mode, draining may begin while the tail is still arriving. All edges use valid/ready handshakes. Header layout: bit 0 of the header word is the destination output, bits 3:1 are the payload length (0 to 7), and the remaining bits are free.

Top module: `ct_switch`

## Requirements
- R1: While reset is held and just after it, every `in_ready` bit is 1 and every `out_valid` bit is 0.
- R2: A packet is forwarded without change on the output named by header bit 0. The header word goes out first, then exactly the number of payload words given by header bits 3:1.
- R3: The header is held in the input's own register from acceptance until the packet is sent. Later changes on `in_data` while the input waits do not alter the header that is sent.
- R4: If, at grant time, the target buffer is empty and that output's `out_ready` is high, the packet bypasses the buffer. Each payload word is visible on `out_data` in the same cycle that the input accepts it.
- R5: If the output is not ready at grant time, the whole packet is stored in the buffer. The input takes every payload word without stalling, even while `out_ready` stays low.
- R6: With `partial_mode` = 0, a stored packet is not presented on the output until its last word is in the buffer.
- R7: With `partial_mode` = 1, a stored packet starts leaving as soon as the output is ready, even while later words are still arriving.
- R8: Inputs contending for one output are served round-robin per output. The input after the one last granted wins, and packets from different inputs never interleave.
- R9: A packet already in an output buffer always leaves before any packet that is granted that output later.
- R10: An input waiting on an output whose buffer has room for fewer than one maximum-length packet (8 words) keeps `in_ready` at 0 until room appears.
- R11: A header with a payload length of 0 is forwarded as a one-word packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| partial_mode | input | 1 | 1 = stored packets may drain before fully stored |
| in_valid | input | N_IN | Word valid per input |
| in_data | input | N_IN*DW | Word per input, input i at bits i*DW upward |
| in_ready | output | N_IN | Word accepted per input |
| out_valid | output | N_OUT | Word valid per output |
| out_ready | input | N_OUT | Downstream channel free per output |
| out_data | output | N_OUT*DW | Word per output, output o at bits o*DW upward |

## Verification
The bench creates conditions where each path choice is observable at the ports.
- **Bypass.** A design that buffered the packet would miss the same-cycle echo of each payload word.
- **Buffering.** A design that never buffered would stall the input while the channel is closed.
- **Mode timing.** In whole-packet mode the output must stay quiet while storing. In early-start mode output must appear while the sender is still busy; a mode swap shows up in either case.
- **Arbitration and order.** A contest right after a single grant exposes a fixed-priority arbiter. A ready channel opening behind a stored packet exposes a bypass that jumps the queue and interleaves two packets.
- **Full buffer.** Filling a buffer exposes a missing room check as buffer overwrite and corrupted output.

// File: rtl/ct_pkg.sv
package ct_pkg;

    typedef enum logic [1:0] {
        IN_IDLE = 2'd0,
        IN_WAIT = 2'd1,
        IN_XFER = 2'd2
    } in_state_e;

    // next round-robin start position after granting cur among n requesters
    function automatic int next_rr(input int cur, input int n);
        return (cur >= n - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/ct_in_port.sv
module ct_in_port
    import ct_pkg::*;
#(
    parameter int DW   = 16,
    parameter int LENW = 3,
    parameter int PW   = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          req,
    output logic [PW-1:0] req_dest,
    input  logic          grant,
    output logic          fwd_valid,
    output logic [DW-1:0] fwd_data,
    output logic          fwd_last,
    input  logic          sink_ready
);
    localparam int CW = LENW + 1;

    in_state_e     st;
    logic [DW-1:0] hdr;
    logic [CW-1:0] remain;
    logic          first;

    assign req       = (st == IN_WAIT);
    assign req_dest  = hdr[PW-1:0];
    assign fwd_valid = (st == IN_XFER) && (first || in_valid);
    assign fwd_data  = first ? hdr : in_data;
    assign fwd_last  = (remain == CW'(1));
    assign in_ready  = (st == IN_IDLE) || ((st == IN_XFER) && !first && sink_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= IN_IDLE;
            hdr    <= '0;
            remain <= '0;
            first  <= 1'b0;
        end else begin
            case (st)
                IN_IDLE: if (in_valid) begin
                    hdr <= in_data;
                    st  <= IN_WAIT;
                end
                IN_WAIT: if (grant) begin
                    remain <= CW'(hdr[PW +: LENW]) + CW'(1);
                    first  <= 1'b1;
                    st     <= IN_XFER;
                end
                IN_XFER: if (fwd_valid && sink_ready) begin
                    first  <= 1'b0;
                    remain <= remain - CW'(1);
                    if (remain == CW'(1)) st <= IN_IDLE;
                end
                default: st <= IN_IDLE;
            endcase
        end
    end

    // R3: latched header does not move while waiting for the output
    p_hdr_held_r3: assert property (@(posedge clk) disable iff (rst)
        (st == IN_WAIT) |=> $stable(hdr));

    // R2: a transfer never starts without a grant
    p_xfer_needs_grant_r2: assert property (@(posedge clk) disable iff (rst)
        (st == IN_WAIT && !grant) |=> (st == IN_WAIT));

endmodule

// File: rtl/ct_out_port.sv
module ct_out_port
    import ct_pkg::*;
#(
    parameter int N_IN  = 2,
    parameter int DW    = 16,
    parameter int LENW  = 3,
    parameter int PW    = 1,
    parameter int DEPTH = 16,
    parameter int IW    = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            partial_mode,
    input  logic [N_IN-1:0] req,
    output logic [N_IN-1:0] grant,
    output logic            owned,
    output logic [IW-1:0]   owner,
    output logic            sink_ready,
    input  logic            src_valid,
    input  logic [DW-1:0]   src_data,
    input  logic            src_last,
    output logic            out_valid,
    output logic [DW-1:0]   out_data,
    input  logic            out_ready
);
    localparam int MAXPKT = 2 ** LENW;
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW   = $clog2(DEPTH + 1);

    logic [DW-1:0]   mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CNTW-1:0] count, pkts;
    logic            rd_active;
    logic [LENW-1:0] rd_left;
    logic            byp;
    logic [IW-1:0]   rr, gidx;
    logic            found, room;
    logic            wr_en, rd_en, wr_done, rd_done, fifo_show, bypassing;
    logic [LENW-1:0] head_len;

    assign room = (int'(count) + MAXPKT) <= DEPTH;

    always_comb begin
        grant = '0;
        gidx  = '0;
        found = 1'b0;
        if (!owned && room) begin
            for (int k = 0; k < N_IN; k++) begin
                if (!found && req[(int'(rr) + k) % N_IN]) begin
                    found = 1'b1;
                    gidx  = IW'((int'(rr) + k) % N_IN);
                end
            end
        end
        if (found) grant[gidx] = 1'b1;
    end

    assign bypassing  = owned && byp;
    assign sink_ready = owned && (byp ? out_ready : 1'b1);
    assign wr_en      = owned && !byp && src_valid;
    assign wr_done    = wr_en && src_last;
    assign fifo_show  = (count != '0) && (rd_active || partial_mode || (pkts != '0));
    assign out_valid  = bypassing ? src_valid : fifo_show;
    assign out_data   = bypassing ? src_data : mem[rp];
    assign rd_en      = !bypassing && fifo_show && out_ready;
    assign head_len   = mem[rp][PW +: LENW];
    assign rd_done    = rd_en && (rd_active ? (rd_left == LENW'(1)) : (head_len == '0));

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= src_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp        <= '0;
            rp        <= '0;
            count     <= '0;
            pkts      <= '0;
            rd_active <= 1'b0;
            rd_left   <= '0;
            owned     <= 1'b0;
            owner     <= '0;
            byp       <= 1'b0;
            rr        <= '0;
        end else begin
            count <= count + CNTW'(wr_en) - CNTW'(rd_en);
            pkts  <= pkts + CNTW'(wr_done) - CNTW'(rd_done);
            if (wr_en) wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + AW'(1);
            if (rd_en) begin
                rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + AW'(1);
                if (!rd_active) begin
                    if (head_len != '0) begin
                        rd_active <= 1'b1;
                        rd_left   <= head_len;
                    end
                end else begin
                    rd_left <= rd_left - LENW'(1);
                    if (rd_left == LENW'(1)) rd_active <= 1'b0;
                end
            end
            if (found) begin
                owned <= 1'b1;
                owner <= gidx;
                byp   <= (count == '0) && out_ready;
                rr    <= IW'(next_rr(int'(gidx), N_IN));
            end else if (owned && src_valid && sink_ready && src_last) begin
                owned <= 1'b0;
                byp   <= 1'b0;
            end
        end
    end

    // R9: bypass only ever runs over an empty buffer, so stored packets go first
    p_bypass_empty_r9: assert property (@(posedge clk) disable iff (rst)
        bypassing |-> (count == '0));

    // R10: buffer never written when full
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(count) < DEPTH));

    // R8: ownership holds until the owner's last word moves
    p_owner_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (owned && !(src_valid && sink_ready && src_last)) |=> (owned && $stable(owner)));

    // R6: in whole-packet mode a stored packet starts only once complete
    p_whole_first_r6: assert property (@(posedge clk) disable iff (rst)
        (!partial_mode && rd_en && !rd_active) |-> (pkts != '0));

endmodule

// File: rtl/ct_switch.sv
module ct_switch
    import ct_pkg::*;
#(
    parameter int N_IN  = 2,
    parameter int N_OUT = 2,
    parameter int DW    = 16,
    parameter int LENW  = 3,
    parameter int DEPTH = 2 * (2 ** LENW)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               partial_mode,
    input  logic [N_IN-1:0]    in_valid,
    input  logic [N_IN*DW-1:0] in_data,
    output logic [N_IN-1:0]    in_ready,
    output logic [N_OUT-1:0]   out_valid,
    input  logic [N_OUT-1:0]   out_ready,
    output logic [N_OUT*DW-1:0] out_data
);
    localparam int PW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
    localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;

    logic [N_IN-1:0]  i_req, i_grant, i_fwd_valid, i_fwd_last, i_sink_ready;
    logic [PW-1:0]    i_dest     [N_IN];
    logic [DW-1:0]    i_fwd_data [N_IN];
    logic [N_IN-1:0]  o_req      [N_OUT];
    logic [N_IN-1:0]  o_grant    [N_OUT];
    logic [IW-1:0]    o_owner    [N_OUT];
    logic [N_OUT-1:0] o_owned, o_sink_ready;

    for (genvar g = 0; g < N_IN; g++) begin : g_in
        ct_in_port #(.DW(DW), .LENW(LENW), .PW(PW)) u_in (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (in_valid[g]),
            .in_data    (in_data[g*DW +: DW]),
            .in_ready   (in_ready[g]),
            .req        (i_req[g]),
            .req_dest   (i_dest[g]),
            .grant      (i_grant[g]),
            .fwd_valid  (i_fwd_valid[g]),
            .fwd_data   (i_fwd_data[g]),
            .fwd_last   (i_fwd_last[g]),
            .sink_ready (i_sink_ready[g])
        );
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++)
            for (int i = 0; i < N_IN; i++)
                o_req[o][i] = i_req[i] && (i_dest[i] == PW'(o));
    end

    always_comb begin
        i_grant = '0;
        for (int o = 0; o < N_OUT; o++) i_grant = i_grant | o_grant[o];
    end

    always_comb begin
        i_sink_ready = '0;
        for (int o = 0; o < N_OUT; o++)
            if (o_owned[o]) i_sink_ready[o_owner[o]] = i_sink_ready[o_owner[o]] | o_sink_ready[o];
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        ct_out_port #(.N_IN(N_IN), .DW(DW), .LENW(LENW), .PW(PW), .DEPTH(DEPTH), .IW(IW)) u_out (
            .clk          (clk),
            .rst          (rst),
            .partial_mode (partial_mode),
            .req          (o_req[g]),
            .grant        (o_grant[g]),
            .owned        (o_owned[g]),
            .owner        (o_owner[g]),
            .sink_ready   (o_sink_ready[g]),
            .src_valid    (i_fwd_valid[o_owner[g]]),
            .src_data     (i_fwd_data[o_owner[g]]),
            .src_last     (i_fwd_last[o_owner[g]]),
            .out_valid    (out_valid[g]),
            .out_data     (out_data[g*DW +: DW]),
            .out_ready    (out_ready[g])
        );
    end

    // R1: outputs quiet in the cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> (out_valid == '0));

endmodule

// File: tb/ct_switch_tb_top.sv
`timescale 1ns/1ps
module ct_switch_tb_top;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          partial = 1'b0;
    logic          iv0 = 1'b0, iv1 = 1'b0;
    logic [DW-1:0] id0 = '0, id1 = '0;
    logic [1:0]    in_ready, out_valid;
    logic [1:0]    out_ready = 2'b00;
    logic [2*DW-1:0] out_data;

    ct_switch #(.N_IN(2), .N_OUT(2), .DW(DW), .LENW(3)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .partial_mode (partial),
        .in_valid     ({iv1, iv0}),
        .in_data      ({id1, id0}),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit busy0 = 1'b0, busy1 = 1'b0;
    logic [DW-1:0] q0[$], q1[$], e0[$], e1[$];

    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (out_valid[0] && out_ready[0]) q0.push_back(out_data[DW-1:0]);
            if (out_valid[1] && out_ready[1]) q1.push_back(out_data[2*DW-1:DW]);
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] hdr_w(input logic [11:0] tag, input int len, input int dest);
        return {tag, 3'(len), 1'(dest)};
    endfunction

    task automatic expect_pkt(input int dest, input int len, input logic [11:0] tag);
        for (int k = 0; k <= len; k++) begin
            if (dest == 0) e0.push_back((k == 0) ? hdr_w(tag, len, dest) : {tag, 4'(k)});
            else           e1.push_back((k == 0) ? hdr_w(tag, len, dest) : {tag, 4'(k)});
        end
    endtask

    task automatic drive(input int p, input logic v, input logic [DW-1:0] d);
        if (p == 0) begin iv0 = v; id0 = d; end
        else        begin iv1 = v; id1 = d; end
    endtask

    task automatic send(input int p, input int dest, input int len, input logic [11:0] tag,
                        input int gap, input bit byp_chk, input bit hold_chk, output int stalls);
        logic [DW-1:0] w;
        stalls = 0;
        if (p == 0) busy0 = 1'b1; else busy1 = 1'b1;
        for (int k = 0; k <= len; k++) begin
            w = (k == 0) ? hdr_w(tag, len, dest) : {tag, 4'(k)};
            if (k > 0) repeat (gap) begin @(negedge clk); drive(p, 1'b0, 16'hDEAD); end
            forever begin
                @(negedge clk);
                drive(p, 1'b1, w);
                #1;
                if (in_ready[p]) begin
                    if (byp_chk && k > 0)
                        chk(out_valid[dest] && out_data[dest*DW +: DW] == w, "R4 bypass word echo",
                            32'(out_data[dest*DW +: DW]), 32'(w));
                    if (hold_chk)
                        chk(!out_valid[dest], "R6 stored packet held back", 32'(out_valid[dest]), 0);
                    break;
                end
                stalls++;
            end
        end
        if (p == 0) busy0 = 1'b0; else busy1 = 1'b0;
        @(negedge clk);
        drive(p, 1'b0, 16'hBEEF);
    endtask

    task automatic cmp(input int d, input string rq);
        logic [DW-1:0] a[$], e[$];
        int bad;
        repeat (40) @(negedge clk);
        if (d == 0) begin a = q0; e = e0; q0 = {}; e0 = {}; end
        else        begin a = q1; e = e1; q1 = {}; e1 = {}; end
        if (a.size() != e.size()) begin
            chk(1'b0, {rq, " word count"}, a.size(), e.size());
        end else begin
            bad = -1;
            foreach (e[k]) if (bad < 0 && a[k] !== e[k]) bad = k;
            if (bad < 0) chk(1'b1, rq, 0, 0);
            else chk(1'b0, {rq, " word order"}, 32'(a[bad]), 32'(e[bad]));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        chk(in_ready == 2'b11, "R1 in_ready in reset", 32'(in_ready), 3);
        chk(out_valid == 2'b00, "R1 out_valid in reset", 32'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(out_valid == 2'b00 && in_ready == 2'b11, "R1 idle after reset",
            32'({out_valid, in_ready}), 32'h3);
    endtask

    task automatic t_bypass();
        int st;
        partial = 1'b0; out_ready = 2'b11;
        expect_pkt(1, 3, 12'h011);
        send(0, 1, 3, 12'h011, 0, 1'b1, 1'b0, st);
        cmp(1, "R2 bypass packet intact");
    endtask

    task automatic t_zero();
        int st;
        expect_pkt(0, 0, 12'h022);
        send(1, 0, 0, 12'h022, 0, 1'b0, 1'b0, st);
        cmp(0, "R11 header-only packet");
    endtask

    task automatic t_full();
        int st;
        partial = 1'b0; out_ready = 2'b00;
        expect_pkt(0, 4, 12'h033);
        send(0, 0, 4, 12'h033, 0, 1'b0, 1'b1, st);
        // two stalls are inherent: grant cycle and header-write cycle
        chk(st == 2, "R5 payload taken without stall", st, 2);
        #1;
        chk(out_valid[0], "R6 complete packet presented", 32'(out_valid[0]), 1);
        out_ready = 2'b11;
        cmp(0, "R5 stored packet intact");
    endtask

    task automatic t_partial();
        int st;
        partial = 1'b1; out_ready = 2'b00;
        expect_pkt(0, 4, 12'h044);
        fork
            send(0, 0, 4, 12'h044, 3, 1'b0, 1'b0, st);
            begin
                repeat (8) @(negedge clk);
                out_ready[0] = 1'b1;
                wait (q0.size() > 0);
                chk(busy0, "R7 drain starts before packet stored", 32'(busy0), 1);
            end
        join
        cmp(0, "R7 early-start packet intact");
        partial = 1'b0; out_ready = 2'b11;
    endtask

    task automatic t_rr();
        int st, st2;
        partial = 1'b0; out_ready = 2'b11;
        expect_pkt(1, 1, 12'h055);
        send(0, 1, 1, 12'h055, 0, 1'b0, 1'b0, st);
        expect_pkt(1, 2, 12'h067);
        expect_pkt(1, 2, 12'h066);
        fork
            send(0, 1, 2, 12'h066, 0, 1'b0, 1'b0, st);
            send(1, 1, 2, 12'h067, 0, 1'b0, 1'b0, st2);
        join
        repeat (20) @(negedge clk);
        chk(q1.size() > 5 && q1[5] == hdr_w(12'h066, 2, 1), "R3 waiting header kept",
            (q1.size() > 5) ? 32'(q1[5]) : 32'hFFFF_FFFF, 32'(hdr_w(12'h066, 2, 1)));
        cmp(1, "R8 round-robin order");
    endtask

    task automatic t_order();
        int st;
        partial = 1'b0; out_ready = 2'b00;
        expect_pkt(0, 3, 12'h077);
        send(0, 0, 3, 12'h077, 0, 1'b0, 1'b0, st);
        out_ready[0] = 1'b1;
        expect_pkt(0, 2, 12'h088);
        send(1, 0, 2, 12'h088, 0, 1'b0, 1'b0, st);
        cmp(0, "R9 stored before later packet");
    endtask

    task automatic t_room();
        int st, st2;
        bit blocked;
        partial = 1'b0; out_ready = 2'b00;
        expect_pkt(0, 7, 12'h099);
        send(0, 0, 7, 12'h099, 0, 1'b0, 1'b0, st);
        expect_pkt(0, 7, 12'h0AA);
        send(0, 0, 7, 12'h0AA, 0, 1'b0, 1'b0, st);
        expect_pkt(0, 2, 12'h0BB);
        fork
            send(1, 0, 2, 12'h0BB, 0, 1'b0, 1'b0, st2);
            begin
                repeat (4) @(negedge clk);
                blocked = 1'b1;
                repeat (10) begin
                    @(negedge clk); #1;
                    if (in_ready[1]) blocked = 1'b0;
                end
                chk(blocked, "R10 input held while buffer full", 32'(!blocked), 0);
                out_ready[0] = 1'b1;
            end
        join
        cmp(0, "R10 packets intact after full buffer");
        out_ready = 2'b11;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_bypass();
        t_zero();
        t_full();
        t_partial();
        t_rr();
        t_order();
        t_room();
        summary();
        $finish;
    end

endmodule